// File: doc/BRIEF.md
# Neuron Configuration SPI Register File

This block is the configuration front end of a stochastic spiking neuron. An external SPI master (Mode 0, active-low chip select, most significant bit first) reaches sixteen byte-wide registers through it. These registers hold the neuron's control bits, the random generator's tap polynomial and seed, the firing threshold, the leak rate, a read-only status byte and an eight-entry activation lookup table. The serial pins are oversampled in the system clock domain. The block drives the registered configuration values straight to the neuron datapath.

A frame is sixteen SCK cycles long. The first byte is a direction bit (1 = read) followed by a 7-bit address, and the second byte carries the data. Two side effects are emitted as single-cycle strobes: a reload of the random generator's seed, and a clear of the membrane accumulator. The datapath also gets its own registered read port into the lookup table. A constant direction mask for the shared pins goes with the serial logic. It marks the MISO pin and the four debug pins as outputs.

Top module: `neuron_cfg_spi`

## Requirements
- R1: After reset: control 0x00, polynomial 0x002D, seed 0xACE1, threshold 0x80, decay 0x01, MISO low, both strobes low. Table entry i holds 0x20 + floor(i*223/7), which gives 0x20, 0x3F, 0x5F, 0x7F, 0x9F, 0xBF, 0xDF, 0xFF.
- R2: A frame is 16 rising SCK edges while CS is low, most significant bit first. Bit 15 is the direction (1 = read), bits 14:8 are the address and bits 7:0 are the data. A write commits on the 16th rising edge.
- R3: On a read, the addressed byte is shifted out on MISO, most significant bit first. MISO changes after the falling edges and is valid at rising edges 9 to 16. MISO stays low during the header byte and while CS is high.
- R4: Address 0x00 holds the control byte. Bit 0 drives the enable output, bit 2 drives the free-run output, and bits 7:5 drive the 3-bit refractory output. Bits 4:3 are stored and read back. Bit 1 always reads back as 0.
- R5: Writing 0x00 with bit 1 set raises the accumulator-clear strobe for exactly one clock. Writing 0x00 with bit 1 clear raises no strobe.
- R6: Addresses 0x01 and 0x02 are the low and high bytes of the 16-bit polynomial output. Addresses 0x03 and 0x04 are the low and high bytes of the 16-bit seed output.
- R7: A write to 0x04 raises the seed-load strobe for exactly one clock, in the first clock where the seed output shows the new value. A write to 0x03 raises no strobe.
- R8: Address 0x05 is the threshold output and 0x06 is the decay output. These outputs change only after a committed write.
- R9: Address 0x07 reads as {5'b0, refractory-active, overflow, spike}, taken from the status inputs. Writes to 0x07 change nothing.
- R10: Addresses 0x08 to 0x0F are table entries 0 to 7, and each can be written and read back. The datapath index port returns the selected entry one clock later.
- R11: Addresses 0x10 to 0x7F ignore writes and read as 0x00.
- R12: A frame whose CS rises before or in the same clock as its 16th rising SCK edge is discarded. It causes no write and no strobe.
- R13: The pad direction mask is 0xF4: bit 2 and bits 7:4 are outputs, and bits 0, 1 and 3 are inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_sck_i | input | 1 | Serial clock |
| spi_mosi_i | input | 1 | Serial data from the master |
| st_spike_i | input | 1 | Status: latched spike flag |
| st_ovf_i | input | 1 | Status: accumulator overflow |
| st_refr_i | input | 1 | Status: refractory active |
| lut_idx_i | input | 3 | Datapath table index |
| miso_o | output | 1 | Serial data to the master |
| pad_oe_o | output | 8 | Direction mask for the shared pins |
| en_o | output | 1 | Neuron enable |
| freerun_o | output | 1 | Free-run select |
| refr_o | output | 3 | Refractory period in clocks |
| poly_o | output | 16 | Generator tap polynomial |
| seed_o | output | 16 | Generator seed |
| seed_load_o | output | 1 | One-clock seed reload strobe |
| accum_clr_o | output | 1 | One-clock accumulator clear strobe |
| thresh_o | output | 8 | Firing threshold |
| decay_o | output | 8 | Leak per clock |
| lut_val_o | output | 8 | Table entry at lut_idx_i, one clock later |

## Verification
The critical coincidence is a chip select that rises in the same system clock as the 16th SCK rising edge is detected. Both pins pass through synchronizers of equal depth, so the abort and the commit condition land on the same cycle. The bench provokes this by raising CS at the same instant as the last SCK rise, on a threshold write and on a seed-high write. It then judges the outcome by reading the threshold output, the seed output and the seed strobe count, which must all stay unchanged. A complete frame with the same content follows and must take effect, which shows that only the timing caused the discard.

// File: rtl/nspi_pkg.sv
package nspi_pkg;

  localparam int DW         = 8;
  localparam int AW         = DW - 1;
  localparam int FRAME_BITS = 2 * DW;
  localparam int LUT_N      = 8;
  localparam int LUT_AW     = $clog2(LUT_N);
  localparam int SYNC_STAGES = 2;

  // register map; the datapath decodes these positions
  localparam logic [AW-1:0] A_CTRL   = 7'h00;
  localparam logic [AW-1:0] A_POLY_L = 7'h01;
  localparam logic [AW-1:0] A_POLY_H = 7'h02;
  localparam logic [AW-1:0] A_SEED_L = 7'h03;
  localparam logic [AW-1:0] A_SEED_H = 7'h04;
  localparam logic [AW-1:0] A_THR    = 7'h05;
  localparam logic [AW-1:0] A_DEC    = 7'h06;
  localparam logic [AW-1:0] A_STAT   = 7'h07;
  localparam logic [AW-1:0] A_LUT0   = 7'h08;

  localparam logic [2*DW-1:0] POLY_RST = 16'h002D;
  localparam logic [2*DW-1:0] SEED_RST = 16'hACE1;
  localparam logic [DW-1:0]   THR_RST  = 8'h80;
  localparam logic [DW-1:0]   DEC_RST  = 8'h01;
  localparam logic [DW-1:0]   LUT_LO   = 8'h20;
  localparam logic [DW-1:0]   LUT_HI   = 8'hFF;

  // shared pin direction: MISO on bit 2, debug taps on 7:4
  localparam logic [7:0] PAD_OE_MASK = 8'hF4;

  typedef struct packed {
    logic [2:0] refr;
    logic [1:0] spare;
    logic       freerun;
    logic       clr;
    logic       en;
  } ctrl_t;

  function automatic logic [DW-1:0] lut_reset(input int idx);
    int span;
    span = int'(LUT_HI) - int'(LUT_LO);
    return DW'(int'(LUT_LO) + (idx * span) / (LUT_N - 1));
  endfunction

endpackage

// File: rtl/nspi_sync.sv
module nspi_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/nspi_frame.sv
module nspi_frame #(
  parameter int DW         = nspi_pkg::DW,
  parameter int AW         = nspi_pkg::AW,
  parameter int FRAME_BITS = nspi_pkg::FRAME_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csn_s,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] hdr_addr_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          miso_o
);

  localparam int CNT_W    = $clog2(FRAME_BITS);
  localparam int HDR_LAST = FRAME_BITS / 2 - 1;
  localparam int LAST     = FRAME_BITS - 1;

  logic             sck_d;
  logic             rise, fall;
  logic [CNT_W-1:0] cnt;
  logic [DW-2:0]    sr;
  logic             rd_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    tx;

  assign rise = sck_s & ~sck_d;
  assign fall = ~sck_s & sck_d;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sr        <= '0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      tx        <= '0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (csn_s) begin
        cnt  <= '0;
        rd_q <= 1'b0;
        tx   <= '0;
      end else begin
        if (rise) begin
          sr  <= {sr[DW-3:0], mosi_s};
          cnt <= (cnt == CNT_W'(LAST)) ? '0 : cnt + 1'b1;
          if (cnt == CNT_W'(HDR_LAST)) begin
            rd_q   <= sr[DW-2];
            addr_q <= {sr[DW-3:0], mosi_s};
          end
          if (cnt == CNT_W'(LAST) && !rd_q) begin
            wr_stb_o  <= 1'b1;
            wr_addr_o <= addr_q;
            wr_data_o <= {sr, mosi_s};
          end
        end
        if (fall) begin
          if (cnt == CNT_W'(HDR_LAST + 1) && rd_q) tx <= rd_data_i;
          else if (cnt > CNT_W'(HDR_LAST + 1))     tx <= {tx[DW-2:0], 1'b0};
          else                                     tx <= '0;
        end
      end
    end
  end

  assign hdr_addr_o = addr_q;
  assign miso_o     = tx[DW-1];

endmodule

// File: rtl/nspi_regs.sv
module nspi_regs
  import nspi_pkg::*;
#(
  parameter int DW    = nspi_pkg::DW,
  parameter int AW    = nspi_pkg::AW,
  parameter int LUT_N = nspi_pkg::LUT_N
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_stb_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic [AW-1:0]             rd_addr_i,
  input  logic                      st_spike_i,
  input  logic                      st_ovf_i,
  input  logic                      st_refr_i,
  input  logic [$clog2(LUT_N)-1:0]  lut_idx_i,
  output logic [DW-1:0]             rd_data_o,
  output logic                      en_o,
  output logic                      freerun_o,
  output logic [2:0]                refr_o,
  output logic [2*DW-1:0]           poly_o,
  output logic [2*DW-1:0]           seed_o,
  output logic                      seed_load_o,
  output logic                      accum_clr_o,
  output logic [DW-1:0]             thresh_o,
  output logic [DW-1:0]             decay_o,
  output logic [DW-1:0]             lut_val_o
);

  localparam int IDX_W = $clog2(LUT_N);

  ctrl_t         ctrl_q;
  logic [DW-1:0] poly_l, poly_h, seed_l, seed_h, thr_q, dec_q;
  logic [DW-1:0] mem [LUT_N];
  logic [DW-1:0] lut_a_q, lut_b_q;
  logic [DW-1:0] rd_mux;
  logic          wr_lut, rd_lut;

  assign wr_lut = (wr_addr_i >= A_LUT0) && (int'(wr_addr_i) < int'(A_LUT0) + LUT_N);
  assign rd_lut = (rd_addr_i >= A_LUT0) && (int'(rd_addr_i) < int'(A_LUT0) + LUT_N);

  // scalar registers and side-effect strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      poly_l      <= POLY_RST[DW-1:0];
      poly_h      <= POLY_RST[2*DW-1:DW];
      seed_l      <= SEED_RST[DW-1:0];
      seed_h      <= SEED_RST[2*DW-1:DW];
      thr_q       <= THR_RST;
      dec_q       <= DEC_RST;
      seed_load_o <= 1'b0;
      accum_clr_o <= 1'b0;
    end else begin
      seed_load_o <= 1'b0;
      accum_clr_o <= 1'b0;
      if (wr_stb_i) begin
        case (wr_addr_i)
          A_CTRL: begin
            ctrl_q      <= ctrl_t'(wr_data_i);
            ctrl_q.clr  <= 1'b0;
            accum_clr_o <= wr_data_i[1];
          end
          A_POLY_L: poly_l <= wr_data_i;
          A_POLY_H: poly_h <= wr_data_i;
          A_SEED_L: seed_l <= wr_data_i;
          A_SEED_H: begin
            seed_h      <= wr_data_i;
            seed_load_o <= 1'b1;
          end
          A_THR:    thr_q <= wr_data_i;
          A_DEC:    dec_q <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  // activation table: one write port, two registered read ports
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LUT_N; i++) mem[i] <= lut_reset(i);
    end else if (wr_stb_i && wr_lut) begin
      mem[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    lut_a_q <= mem[rd_addr_i[IDX_W-1:0]];
    lut_b_q <= mem[lut_idx_i];
  end

  always_comb begin
    rd_mux = '0;
    if (rd_lut) begin
      rd_mux = lut_a_q;
    end else begin
      case (rd_addr_i)
        A_CTRL:   rd_mux = ctrl_q;
        A_POLY_L: rd_mux = poly_l;
        A_POLY_H: rd_mux = poly_h;
        A_SEED_L: rd_mux = seed_l;
        A_SEED_H: rd_mux = seed_h;
        A_THR:    rd_mux = thr_q;
        A_DEC:    rd_mux = dec_q;
        A_STAT:   rd_mux = {{(DW-3){1'b0}}, st_refr_i, st_ovf_i, st_spike_i};
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_mux;
  end

  assign en_o      = ctrl_q.en;
  assign freerun_o = ctrl_q.freerun;
  assign refr_o    = ctrl_q.refr;
  assign poly_o    = {poly_h, poly_l};
  assign seed_o    = {seed_h, seed_l};
  assign thresh_o  = thr_q;
  assign decay_o   = dec_q;
  assign lut_val_o = lut_b_q;

endmodule

// File: rtl/neuron_cfg_spi.sv
module neuron_cfg_spi
  import nspi_pkg::*;
#(
  parameter int DW    = nspi_pkg::DW,
  parameter int LUT_N = nspi_pkg::LUT_N
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     spi_csn_i,
  input  logic                     spi_sck_i,
  input  logic                     spi_mosi_i,
  input  logic                     st_spike_i,
  input  logic                     st_ovf_i,
  input  logic                     st_refr_i,
  input  logic [$clog2(LUT_N)-1:0] lut_idx_i,
  output logic                     miso_o,
  output logic [7:0]               pad_oe_o,
  output logic                     en_o,
  output logic                     freerun_o,
  output logic [2:0]               refr_o,
  output logic [2*DW-1:0]          poly_o,
  output logic [2*DW-1:0]          seed_o,
  output logic                     seed_load_o,
  output logic                     accum_clr_o,
  output logic [DW-1:0]            thresh_o,
  output logic [DW-1:0]            decay_o,
  output logic [DW-1:0]            lut_val_o
);

  localparam int AW = DW - 1;

  logic          csn_s, sck_s, mosi_s;
  logic [AW-1:0] hdr_addr;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;

  nspi_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({spi_csn_i, spi_sck_i, spi_mosi_i}),
    .q_o ({csn_s, sck_s, mosi_s})
  );

  nspi_frame #(
    .DW         (DW),
    .AW         (AW),
    .FRAME_BITS (2 * DW)
  ) u_frame (
    .clk        (clk),
    .rst        (rst),
    .csn_s      (csn_s),
    .sck_s      (sck_s),
    .mosi_s     (mosi_s),
    .rd_data_i  (rd_data),
    .hdr_addr_o (hdr_addr),
    .wr_stb_o   (wr_stb),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .miso_o     (miso_o)
  );

  nspi_regs #(
    .DW    (DW),
    .AW    (AW),
    .LUT_N (LUT_N)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_stb_i    (wr_stb),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (hdr_addr),
    .st_spike_i  (st_spike_i),
    .st_ovf_i    (st_ovf_i),
    .st_refr_i   (st_refr_i),
    .lut_idx_i   (lut_idx_i),
    .rd_data_o   (rd_data),
    .en_o        (en_o),
    .freerun_o   (freerun_o),
    .refr_o      (refr_o),
    .poly_o      (poly_o),
    .seed_o      (seed_o),
    .seed_load_o (seed_load_o),
    .accum_clr_o (accum_clr_o),
    .thresh_o    (thresh_o),
    .decay_o     (decay_o),
    .lut_val_o   (lut_val_o)
  );

  assign pad_oe_o = PAD_OE_MASK;

endmodule

// File: rtl/nspi_chk.sv
module nspi_chk #(
  parameter int DW = nspi_pkg::DW
) (
  input logic          clk,
  input logic          rst,
  input logic          csn_s,
  input logic          wr_stb,
  input logic [DW-2:0] wr_addr,
  input logic          miso_o,
  input logic          seed_load_o,
  input logic          accum_clr_o,
  input logic [DW-1:0] thresh_o
);

  a_r7_seed_single: assert property (@(posedge clk) disable iff (rst)
    seed_load_o |=> !seed_load_o);

  a_r7_seed_cause: assert property (@(posedge clk) disable iff (rst)
    seed_load_o |-> $past(wr_stb && wr_addr == nspi_pkg::A_SEED_H));

  a_r5_clr_single: assert property (@(posedge clk) disable iff (rst)
    accum_clr_o |=> !accum_clr_o);

  a_r3_miso_idle: assert property (@(posedge clk) disable iff (rst)
    $past(csn_s) |-> !miso_o);

  a_r8_thresh_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_stb) |-> $stable(thresh_o));

  a_r12_no_write_deselected: assert property (@(posedge clk) disable iff (rst)
    $past(csn_s) |-> !wr_stb);

endmodule

bind neuron_cfg_spi nspi_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .csn_s       (csn_s),
  .wr_stb      (wr_stb),
  .wr_addr     (wr_addr),
  .miso_o      (miso_o),
  .seed_load_o (seed_load_o),
  .accum_clr_o (accum_clr_o),
  .thresh_o    (thresh_o)
);

// File: tb/sim_neuron_cfg_spi.sv
`timescale 1ns/1ps
module sim_neuron_cfg_spi;

  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic        st_spike = 1'b0, st_ovf = 1'b0, st_refr = 1'b0;
  logic [2:0]  lut_idx = 3'd0;
  logic        miso;
  logic [7:0]  pad_oe;
  logic        en, freerun;
  logic [2:0]  refr;
  logic [15:0] poly, seed;
  logic        seed_load, accum_clr;
  logic [7:0]  thresh, decay, lut_val;

  int checks = 0, errors = 0;
  bit done = 0, hdr_bad = 0;
  int seed_hi_cyc = 0, seed_pulses = 0, clr_hi_cyc = 0, clr_pulses = 0;
  logic        seed_prev = 0, clr_prev = 0;
  logic [15:0] seed_at_strobe = '0;

  always #2.5 clk = ~clk;

  neuron_cfg_spi u0 (
    .clk(clk), .rst(rst), .spi_csn_i(spi_csn), .spi_sck_i(spi_sck),
    .spi_mosi_i(spi_mosi), .st_spike_i(st_spike), .st_ovf_i(st_ovf),
    .st_refr_i(st_refr), .lut_idx_i(lut_idx), .miso_o(miso), .pad_oe_o(pad_oe),
    .en_o(en), .freerun_o(freerun), .refr_o(refr), .poly_o(poly), .seed_o(seed),
    .seed_load_o(seed_load), .accum_clr_o(accum_clr), .thresh_o(thresh),
    .decay_o(decay), .lut_val_o(lut_val)
  );

  // strobe monitors, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (seed_load) begin
        seed_hi_cyc++;
        seed_at_strobe = seed;
        if (!seed_prev) seed_pulses++;
      end
      if (accum_clr) begin
        clr_hi_cyc++;
        if (!clr_prev) clr_pulses++;
      end
    end
    seed_prev = seed_load;
    clr_prev  = accum_clr;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic spi_xfer(input logic [15:0] fr, input int nbits, input bit cs_at_last,
                          output logic [7:0] rx);
    rx = '0;
    spi_csn = 1'b0;
    spi_mosi = fr[15];
    wait_clk(HP);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = fr[15-i];
      wait_clk(HP);
      if (i >= 8) rx = {rx[6:0], miso};
      else if (miso !== 1'b0) hdr_bad = 1;
      spi_sck = 1'b1;
      if (cs_at_last && i == nbits - 1) spi_csn = 1'b1;
      wait_clk(HP);
      spi_sck = 1'b0;
    end
    wait_clk(HP);
    spi_csn = 1'b1;
    wait_clk(3 * HP);
  endtask

  task automatic spi_wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] junk;
    spi_xfer({1'b0, a, d}, 16, 1'b0, junk);
  endtask

  task automatic spi_rd(input logic [6:0] a, output logic [7:0] d);
    spi_xfer({1'b1, a, 8'h00}, 16, 1'b0, d);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  typedef struct packed {
    logic [6:0] a;
    logic [7:0] w;
    logic [7:0] e;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VT [11] = '{
    '{7'h05, 8'h3C, 8'h3C, 4'd8},   // R8 threshold
    '{7'h06, 8'hA5, 8'hA5, 4'd2},   // R2 bit order through a full frame
    '{7'h06, 8'h07, 8'h07, 4'd8},   // R8 decay
    '{7'h01, 8'h0B, 8'h0B, 4'd6},   // R6 polynomial low
    '{7'h02, 8'h80, 8'h80, 4'd6},   // R6 polynomial high
    '{7'h03, 8'h5A, 8'h5A, 4'd6},   // R6 seed low
    '{7'h00, 8'hFB, 8'hF9, 4'd4},   // R4 clear bit reads back 0
    '{7'h08, 8'h11, 8'h11, 4'd10},  // R10 first entry
    '{7'h0F, 8'h00, 8'h00, 4'd10},  // R10 last entry
    '{7'h07, 8'hFF, 8'h05, 4'd9},   // R9 status, write ignored
    '{7'h10, 8'hAA, 8'h00, 4'd11}   // R11 unmapped
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [7:0] rd;
    wait_clk(10);
    rst = 1'b0;
    wait_clk(3);

    // R1 reset state
    chk("R1 poly", poly, 16'h002D);
    chk("R1 seed", seed, 16'hACE1);
    chk("R1 thresh", thresh, 8'h80);
    chk("R1 decay", decay, 8'h01);
    chk("R1 ctrl outs", {en, freerun, refr}, 5'b0);
    chk("R1 strobes", {seed_load, accum_clr, miso}, 3'b0);
    lut_idx = 3'd3; wait_clk(2);
    chk("R1 lut3", lut_val, 8'h7F);
    lut_idx = 3'd7; wait_clk(2);
    chk("R1 lut7", lut_val, 8'hFF);
    chk("R13 pad mask", pad_oe, 8'hF4);
    spi_rd(7'h0C, rd);
    chk("R1 lut4 via spi", rd, 8'h9F);
    spi_rd(7'h00, rd);
    chk("R1 ctrl via spi", rd, 8'h00);

    // vector table
    st_spike = 1'b1; st_ovf = 1'b0; st_refr = 1'b1;
    for (int i = 0; i < 11; i++) begin
      spi_wr(VT[i].a, VT[i].w);
      spi_rd(VT[i].a, rd);
      chk($sformatf("R%0d vector %0d", VT[i].req, i), rd, VT[i].e);
    end

    chk("R8 thresh out", thresh, 8'h3C);
    chk("R8 decay out", decay, 8'h07);
    chk("R6 poly out", poly, 16'h800B);
    chk("R6 seed out", seed, 16'hAC5A);
    chk("R4 ctrl outs", {en, freerun, refr}, {1'b1, 1'b0, 3'd7});
    chk("R5 clear pulses", clr_pulses, 1);
    chk("R5 clear width", clr_hi_cyc, 1);
    chk("R7 no strobe from low byte", seed_pulses, 0);

    // R7 seed reload strobe
    spi_wr(7'h04, 8'h12);
    chk("R7 seed pulses", seed_pulses, 1);
    chk("R7 seed width", seed_hi_cyc, 1);
    chk("R7 seed at strobe", seed_at_strobe, 16'h125A);
    chk("R6 seed high", seed, 16'h125A);

    // R10 datapath read port
    lut_idx = 3'd0; wait_clk(2);
    chk("R10 port idx0", lut_val, 8'h11);
    lut_idx = 3'd7; wait_clk(2);
    chk("R10 port idx7", lut_val, 8'h00);
    lut_idx = 3'd1; wait_clk(2);
    chk("R10 port idx1", lut_val, 8'h3F);

    // R9 other status pattern
    st_spike = 1'b0; st_ovf = 1'b1; st_refr = 1'b0;
    spi_rd(7'h07, rd);
    chk("R9 status ovf", rd, 8'h02);

    // R11 top address
    spi_wr(7'h7F, 8'h55);
    spi_rd(7'h7F, rd);
    chk("R11 top address", rd, 8'h00);

    // R12 aborted frames
    spi_xfer({1'b0, 7'h05, 8'h99}, 10, 1'b0, rd);
    chk("R12 short frame", thresh, 8'h3C);
    spi_xfer({1'b0, 7'h05, 8'h99}, 16, 1'b1, rd);
    chk("R12 cs with last edge", thresh, 8'h3C);
    spi_xfer({1'b0, 7'h04, 8'h77}, 16, 1'b1, rd);
    chk("R12 no seed strobe", seed_pulses, 1);
    chk("R12 seed kept", seed, 16'h125A);
    spi_wr(7'h05, 8'h99);
    chk("R12 full frame commits", thresh, 8'h99);

    // R5 no strobe when bit 1 is clear
    spi_wr(7'h00, 8'h05);
    chk("R5 no extra clear", clr_pulses, 1);
    chk("R4 free-run", {en, freerun, refr}, {1'b1, 1'b1, 3'd0});
    spi_rd(7'h00, rd);
    chk("R4 ctrl readback", rd, 8'h05);

    // R3 header and idle MISO
    chk("R3 miso low in header", hdr_bad, 0);
    chk("R3 miso idle", miso, 1'b0);

    done = 1;
    finish_run();
  end

endmodule